// File: doc/BRIEF.md
# Atomic Event Ordering Monitor

This block observes the retiring memory references of a multi-line atomic event and checks that they follow a two-phase order. In the setup phase the event names the cache lines it will touch through locked loads and locked prefetches. In the manifestation phase it modifies those lines. A single locked store then ends the event. Either a query marker or the first plain store to a tracked line opens the manifestation phase.

The block keeps a small fully associative set of tracked line tags. If a reference breaks the order, a locked store misses the tracked lines, or the event names more lines than the set holds, the monitor raises an operation fault. It then latches a cause code, drops every tracked line and returns to idle. The surrounding pipeline uses the phase output, the fault pulse with its cause, and the completion pulse to decide whether the event commits or traps.

Instructions arrive one per cycle as a record with a valid/ready handshake. Every state change takes effect at the clock edge that accepts the record and is visible on the registered outputs right after that edge.

Top module: `aem_monitor`

## Requirements
- R1: After reset, `phase_o` is 0 (idle), `fault_o` and `done_o` are low, `cause_o` is 0 and `in_ready` is high. An accepted record with `in_start` high empties the tracked-line set, sets `cause_o` to 0 and moves the phase to 1 (setup), whatever the current phase. The kind of a start record has no other effect.
- R2: While the phase is idle, every record without `in_start` is ignored. The phase stays 0, no pulse is raised and `cause_o` keeps its value.
- R3: In setup, a locked load (kind 0) or locked prefetch (kind 1) to an untracked line takes a new entry. A line is address bits [AW-1:6], so lines are 64 bytes. A later reference to a line already tracked takes no entry. Eight distinct lines fit without a fault, however often each one repeats.
- R4: In setup, a locked load or locked prefetch that would need a ninth entry faults with cause 2.
- R5: In setup, a query record (kind 2) moves the phase to 2 (manifestation).
- R6: In setup, an unlocked store (kind 4, lock 0) to a tracked line moves the phase to 2. An unlocked store to an untracked line leaves the phase at setup.
- R7: In manifestation, a locked load or locked prefetch faults with cause 1.
- R8: An ordinary load (kind 3) never changes the phase and never faults, whether it arrives in setup or in manifestation. Unlocked stores in manifestation have no effect either.
- R9: In manifestation, a query record faults with cause 3.
- R10: A locked store (kind 4, lock 1) to a tracked line, in setup or in manifestation, completes the event. `done_o` is high for exactly one cycle, no fault is raised and the phase returns to 0.
- R11: A locked store to an untracked line during an event faults with cause 4.
- R12: Every fault returns the phase to 0 and pulses `fault_o` for exactly one cycle. `cause_o` keeps the cause until the next start record. `fault_o` and `done_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An instruction record is offered |
| in_ready | output | 1 | The monitor accepts a record this cycle |
| in_start | input | 1 | Record opens a new atomic event |
| in_kind | input | 3 | 0 locked load, 1 locked prefetch, 2 query, 3 ordinary load, 4 store, others ignored |
| in_lock | input | 1 | Lock bit; meaningful on stores only |
| in_addr | input | AW | Byte address of the reference |
| phase_o | output | 2 | 0 idle, 1 setup, 2 manifestation |
| fault_o | output | 1 | One-cycle operation fault pulse |
| cause_o | output | 3 | Last fault cause: 0 none, 1 late participating ref, 2 overflow, 3 late query, 4 stray locked store |
| done_o | output | 1 | One-cycle event completion pulse |

## Verification
A wrong tracked-line set shows up as a membership error. A lost or duplicated entry makes a plain store stay in setup when it should open manifestation, makes a locked store fault with cause 4 instead of completing, or makes an overflow appear one line early or late. All of these are visible on `phase_o`, `fault_o` and `cause_o` one cycle after the offending record. A wrong phase register shows in the same cycle as a fault or completion that is missing or unexpected. The scenarios therefore place each membership-dependent decision right after the lines it depends on have been entered, repeated or left out.

// File: rtl/aem_pkg.sv
package aem_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_MANIF = 2'd2
  } phase_t;

  typedef enum logic [2:0] {
    K_LLOAD = 3'd0,
    K_LPREF = 3'd1,
    K_QUERY = 3'd2,
    K_LOAD  = 3'd3,
    K_STORE = 3'd4
  } kind_t;

  typedef enum logic [2:0] {
    CA_NONE  = 3'd0,
    CA_LATE  = 3'd1,
    CA_OVF   = 3'd2,
    CA_QLATE = 3'd3,
    CA_STRAY = 3'd4
  } cause_t;

endpackage

// File: rtl/aem_decode.sv
module aem_decode
  import aem_pkg::*;
(
  input  logic [2:0] kind,
  output logic       is_part,
  output logic       is_query,
  output logic       is_store
);
  // Only the three classes the phase logic acts on are produced;
  // ordinary loads and reserved codes fall through as no-ops.
  always_comb begin
    is_part  = 1'b0;
    is_query = 1'b0;
    is_store = 1'b0;
    case (kind)
      K_LLOAD, K_LPREF: is_part  = 1'b1;
      K_QUERY:          is_query = 1'b1;
      K_STORE:          is_store = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/aem_line_table.sv
module aem_line_table #(
  parameter int NLINES = 8,
  parameter int TAGW   = 26
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            ins,
  input  logic [TAGW-1:0] tag,
  output logic            hit,
  output logic            full
);
  localparam int CW = $clog2(NLINES + 1);
  localparam int IW = $clog2(NLINES);

  logic [TAGW-1:0]   tags [NLINES];
  logic [NLINES-1:0] vld;
  logic [NLINES-1:0] hv;
  logic [CW-1:0]     cnt;

  // One comparator per entry.
  for (genvar i = 0; i < NLINES; i++) begin : g_cmp
    assign hv[i] = vld[i] && (tags[i] == tag);
  end

  assign hit  = |hv;
  assign full = (cnt == CW'(NLINES));

  // Entries fill in order, so the count doubles as the write pointer.
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      vld <= '0;
      cnt <= '0;
    end else if (ins && !full) begin
      vld[cnt[IW-1:0]] <= 1'b1;
      cnt <= cnt + 1'b1;
    end
  end

  // Tag storage: no reset, written like a small memory.
  always_ff @(posedge clk) begin
    if (ins && !full) tags[cnt[IW-1:0]] <= tag;
  end

  // R3: a line never sits in two entries
  a_r3_single_match: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hv));

  // R4: the fill count never passes the capacity
  a_r4_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(NLINES));

  // R3: the number of valid entries follows the fill count
  a_r3_count_match: assert property (@(posedge clk) disable iff (rst)
    $countones(vld) == int'(cnt));
endmodule

// File: rtl/aem_phase_ctrl.sv
module aem_phase_ctrl
  import aem_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       acc,
  input  logic       start,
  input  logic       is_part,
  input  logic       is_query,
  input  logic       is_store,
  input  logic       lock,
  input  logic       hit,
  input  logic       full,
  output phase_t     phase_q,
  output logic       fault_q,
  output cause_t     cause_q,
  output logic       done_q,
  output logic       tbl_clr,
  output logic       tbl_ins
);
  phase_t nph;
  cause_t nca;
  logic   nfl, ndn;

  always_comb begin
    nph     = phase_q;
    nca     = cause_q;
    nfl     = 1'b0;
    ndn     = 1'b0;
    tbl_clr = 1'b0;
    tbl_ins = 1'b0;
    if (acc) begin
      if (start) begin
        nph     = PH_SETUP;
        nca     = CA_NONE;
        tbl_clr = 1'b1;
      end else begin
        case (phase_q)
          PH_SETUP: begin
            if (is_part) begin
              if (!hit) begin
                if (full) begin
                  nph = PH_IDLE; nfl = 1'b1; nca = CA_OVF; tbl_clr = 1'b1;
                end else begin
                  tbl_ins = 1'b1;
                end
              end
            end else if (is_query) begin
              nph = PH_MANIF;
            end else if (is_store) begin
              if (lock) begin
                if (hit) begin
                  nph = PH_IDLE; ndn = 1'b1; tbl_clr = 1'b1;
                end else begin
                  nph = PH_IDLE; nfl = 1'b1; nca = CA_STRAY; tbl_clr = 1'b1;
                end
              end else if (hit) begin
                nph = PH_MANIF;
              end
            end
          end
          PH_MANIF: begin
            if (is_part) begin
              nph = PH_IDLE; nfl = 1'b1; nca = CA_LATE; tbl_clr = 1'b1;
            end else if (is_query) begin
              nph = PH_IDLE; nfl = 1'b1; nca = CA_QLATE; tbl_clr = 1'b1;
            end else if (is_store && lock) begin
              if (hit) begin
                nph = PH_IDLE; ndn = 1'b1; tbl_clr = 1'b1;
              end else begin
                nph = PH_IDLE; nfl = 1'b1; nca = CA_STRAY; tbl_clr = 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cause_q <= CA_NONE;
      fault_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= nph;
      cause_q <= nca;
      fault_q <= nfl;
      done_q  <= ndn;
    end
  end

  // R7: a participating reference during manifestation faults with cause 1
  a_r7_late_part: assert property (@(posedge clk) disable iff (rst)
    (acc && !start && phase_q == PH_MANIF && is_part)
      |=> (fault_q && cause_q == CA_LATE));

  // R9: a query during manifestation faults with cause 3
  a_r9_late_query: assert property (@(posedge clk) disable iff (rst)
    (acc && !start && phase_q == PH_MANIF && is_query)
      |=> (fault_q && cause_q == CA_QLATE));

  // R2: records seen while idle change nothing
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (acc && !start && phase_q == PH_IDLE)
      |=> (phase_q == PH_IDLE && !fault_q && !done_q));

  // R12: fault and completion never coincide
  a_r12_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(fault_q && done_q));

  // R10, R12: both pulses leave the monitor idle
  a_r10_pulse_idle: assert property (@(posedge clk) disable iff (rst)
    (done_q || fault_q) |-> phase_q == PH_IDLE);

  // R12: the cause holds while no record is accepted
  a_r12_cause_hold: assert property (@(posedge clk) disable iff (rst)
    !acc |=> $stable(cause_q));

  // R1: a start record always lands in setup with a clean cause
  a_r1_start_setup: assert property (@(posedge clk) disable iff (rst)
    (acc && start) |=> (phase_q == PH_SETUP && cause_q == CA_NONE));
endmodule

// File: rtl/aem_monitor.sv
module aem_monitor
  import aem_pkg::*;
#(
  parameter int AW         = 32,
  parameter int NLINES     = 8,
  parameter int LINE_BYTES = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_start,
  input  logic [2:0]    in_kind,
  input  logic          in_lock,
  input  logic [AW-1:0] in_addr,
  output logic [1:0]    phase_o,
  output logic          fault_o,
  output logic [2:0]    cause_o,
  output logic          done_o
);
  localparam int OFFW = $clog2(LINE_BYTES);
  localparam int TAGW = AW - OFFW;

  logic            rdy_q;
  logic            acc;
  logic            is_part, is_query, is_store;
  logic            hit, full, tbl_clr, tbl_ins;
  logic [TAGW-1:0] tag;
  phase_t          ph;
  cause_t          ca;

  always_ff @(posedge clk) begin
    if (rst) rdy_q <= 1'b0;
    else     rdy_q <= 1'b1;
  end

  assign in_ready = rdy_q;
  assign acc      = in_valid && rdy_q;
  assign tag      = in_addr[AW-1:OFFW];

  aem_decode u_dec (
    .kind     (in_kind),
    .is_part  (is_part),
    .is_query (is_query),
    .is_store (is_store)
  );

  aem_line_table #(.NLINES(NLINES), .TAGW(TAGW)) u_tbl (
    .clk  (clk),
    .rst  (rst),
    .clr  (tbl_clr),
    .ins  (tbl_ins),
    .tag  (tag),
    .hit  (hit),
    .full (full)
  );

  aem_phase_ctrl u_ctl (
    .clk      (clk),
    .rst      (rst),
    .acc      (acc),
    .start    (in_start),
    .is_part  (is_part),
    .is_query (is_query),
    .is_store (is_store),
    .lock     (in_lock),
    .hit      (hit),
    .full     (full),
    .phase_q  (ph),
    .fault_q  (fault_o),
    .cause_q  (ca),
    .done_q   (done_o),
    .tbl_clr  (tbl_clr),
    .tbl_ins  (tbl_ins)
  );

  assign phase_o = ph;
  assign cause_o = ca;

  // R10: a completion is preceded by an accepted locked store
  a_r10_done_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> $past(acc && in_kind == 3'd4 && in_lock));
endmodule

// File: tb/sim_aem_monitor.sv
module sim_aem_monitor;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        vld = 1'b0;
  logic        rdy;
  logic        st = 1'b0;
  logic [2:0]  knd = 3'd0;
  logic        lk = 1'b0;
  logic [31:0] adr = '0;
  logic [1:0]  ph;
  logic        flt, dn;
  logic [2:0]  ca;

  int total = 0;
  int bad   = 0;
  bit ended = 1'b0;

  typedef struct {
    logic [1:0] ph;
    logic       f;
    logic [2:0] c;
    logic       d;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  aem_monitor u0 (
    .clk(clk), .rst(rst), .in_valid(vld), .in_ready(rdy), .in_start(st),
    .in_kind(knd), .in_lock(lk), .in_addr(adr), .phase_o(ph),
    .fault_o(flt), .cause_o(ca), .done_o(dn)
  );

  function automatic logic [31:0] ln(int n, int off);
    return 32'(n * 64 + off);
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Scoreboard monitor: one expected item per accepted record.
  always @(posedge clk) begin
    if (!rst && vld && rdy) begin
      #2;
      if (q.size() == 0) begin
        chk("R0", "unexpected_result", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(e.tag, "phase", int'(ph),  int'(e.ph));
        chk(e.tag, "fault", int'(flt), int'(e.f));
        chk(e.tag, "cause", int'(ca),  int'(e.c));
        chk(e.tag, "done",  int'(dn),  int'(e.d));
      end
    end
  end

  task automatic send(logic s, logic [2:0] k, logic l, logic [31:0] a,
                      logic [1:0] eph, logic ef, logic [2:0] ec, logic ed,
                      string tag);
    exp_t e;
    @(negedge clk);
    vld = 1'b1; st = s; knd = k; lk = l; adr = a;
    e.ph = eph; e.f = ef; e.c = ec; e.d = ed; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    vld = 1'b0; st = 1'b0;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 20000);
    bad++;
    $display("FAIL R0 watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1", "reset_phase", int'(ph),  0);
    chk("R1", "reset_fault", int'(flt), 0);
    chk("R1", "reset_cause", int'(ca),  0);
    chk("R1", "reset_done",  int'(dn),  0);
    chk("R1", "reset_ready", int'(rdy), 1);

    // R2: records while idle are ignored
    send(0, 3'd0, 0, ln(1, 0), 2'd0, 0, 3'd0, 0, "R2");
    send(0, 3'd4, 1, ln(1, 0), 2'd0, 0, 3'd0, 0, "R2");

    // Event A: query path and completion
    send(1, 3'd3, 0, 0,        2'd1, 0, 3'd0, 0, "R1");
    send(0, 3'd0, 0, ln(0, 4), 2'd1, 0, 3'd0, 0, "R3");
    send(0, 3'd3, 0, ln(5, 0), 2'd1, 0, 3'd0, 0, "R8");
    send(0, 3'd2, 0, 0,        2'd2, 0, 3'd0, 0, "R5");
    send(0, 3'd3, 0, ln(6, 0), 2'd2, 0, 3'd0, 0, "R8");
    send(0, 3'd4, 0, ln(0, 8), 2'd2, 0, 3'd0, 0, "R8");
    send(0, 3'd4, 1, ln(0, 0), 2'd0, 0, 3'd0, 1, "R10");
    send(0, 3'd3, 0, ln(0, 0), 2'd0, 0, 3'd0, 0, "R10");

    // Event B: store-opened manifestation, late participating ref
    send(1, 3'd0, 0, 0,        2'd1, 0, 3'd0, 0, "R1");
    send(0, 3'd1, 0, ln(1, 0), 2'd1, 0, 3'd0, 0, "R3");
    send(0, 3'd4, 0, ln(9, 0), 2'd1, 0, 3'd0, 0, "R6");
    send(0, 3'd4, 0, ln(1, 32),2'd2, 0, 3'd0, 0, "R6");
    send(0, 3'd1, 0, ln(2, 0), 2'd0, 1, 3'd1, 0, "R7");
    send(0, 3'd0, 0, ln(2, 0), 2'd0, 0, 3'd1, 0, "R12");
    idle_cycle();
    idle_cycle();

    // Event C: eight lines with repeats fit, a ninth overflows
    send(1, 3'd0, 0, 0, 2'd1, 0, 3'd0, 0, "R1");
    for (int i = 0; i < 8; i++) begin
      send(0, 3'd0, 0, ln(i + 16, 0), 2'd1, 0, 3'd0, 0, "R3");
      send(0, 3'd1, 0, ln(i + 16, 8), 2'd1, 0, 3'd0, 0, "R3");
    end
    send(0, 3'd0, 0, ln(40, 0), 2'd0, 1, 3'd2, 0, "R4");

    // Event D: query after manifestation
    send(1, 3'd0, 0, 0,        2'd1, 0, 3'd0, 0, "R1");
    send(0, 3'd0, 0, ln(3, 0), 2'd1, 0, 3'd0, 0, "R3");
    send(0, 3'd2, 0, 0,        2'd2, 0, 3'd0, 0, "R5");
    send(0, 3'd2, 0, 0,        2'd0, 1, 3'd3, 0, "R9");

    // Event E: locked store to an untracked line
    send(1, 3'd0, 0, 0,        2'd1, 0, 3'd0, 0, "R1");
    send(0, 3'd0, 0, ln(4, 0), 2'd1, 0, 3'd0, 0, "R3");
    send(0, 3'd4, 1, ln(7, 0), 2'd0, 1, 3'd4, 0, "R11");

    // Event F: locked store completes straight from setup; restart mid-event
    send(1, 3'd0, 0, 0,        2'd1, 0, 3'd0, 0, "R1");
    send(0, 3'd0, 0, ln(8, 0), 2'd1, 0, 3'd0, 0, "R3");
    send(0, 3'd2, 0, 0,        2'd2, 0, 3'd0, 0, "R5");
    send(1, 3'd2, 0, 0,        2'd1, 0, 3'd0, 0, "R1");
    send(0, 3'd4, 1, ln(8, 0), 2'd0, 1, 3'd4, 0, "R11");
    send(1, 3'd0, 0, 0,        2'd1, 0, 3'd0, 0, "R1");
    send(0, 3'd0, 0, ln(8, 0), 2'd1, 0, 3'd0, 0, "R3");
    send(0, 3'd4, 1, ln(8, 2), 2'd0, 0, 3'd0, 1, "R10");
    idle_cycle();
    idle_cycle();
    idle_cycle();
    chk("R12", "queue_empty", q.size(), 0);
    finish_run();
  end
endmodule